// File: doc/BRIEF.md
# Predicated Register File with Guarded Writeback

This block holds the architectural state of a small wide-issue core: a bank of 64 general registers of 64 bits and a bank of 16 single-bit predicate registers. Each issue slot reads its operands through combinational read ports. Results come back through two general write ports and one predicate write port. Comparison results use the predicate port.

Every write request names a guard predicate by a 4-bit index and may carry an invert flag. A request commits at the next rising clock edge only when it is valid and its guard, after the optional inversion, evaluates true. Otherwise the destination keeps its old contents. General register 0 is a constant zero. Predicate register 0 is a constant one. Guarding on predicate 0 therefore makes a write unconditional, and guarding on its inverse makes the write never happen.

Top module: `rfp_regfile`

## Requirements
- R1: A read of general register 0 returns zero, and a committed write to register 0 changes nothing that any read port returns.
- R2: A general read port returns, in the same cycle, the content of the register at its address. A write committed at a clock edge is visible from that edge on. A read in the cycle of the write returns the old value.
- R3: A read of predicate register 0 returns 1 at all times. A write to predicate register 0 has no effect.
- R4: A general write request commits only when its valid bit is 1 and its guard is true. The guard is the predicate selected by the 4-bit guard index (0 to 15), inverted when the invert flag is 1. A request that does not commit leaves its destination unchanged.
- R5: The predicate write port stores its 1-bit value into the predicate register selected by its 4-bit destination index. It is gated by its own guard index and invert flag in the same way as R4.
- R6: When the invert flag is 1, a request commits exactly when the selected predicate is 0. So an inverted guard on predicate 0 never commits.
- R7: When both general write ports commit to the same nonzero register in one cycle, port 1's data is stored. When only one of them commits, that port's data is stored.
- R8: Guards are evaluated on predicate values from before the current edge. A predicate write in the same cycle does not change whether a general or predicate write in that cycle commits.
- R9: A synchronous active-high reset clears all general registers and predicate registers 1 to 15 to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_addr | input | 4x6 | General read addresses, one per read port |
| rd_data | output | 4x64 | General read data |
| prd_idx | input | 2x4 | Predicate read indices |
| prd_val | output | 2 | Predicate read values |
| wb_vld | input | 2 | General write port valid bits |
| wb_pidx | input | 2x4 | Guard predicate index per general write port |
| wb_pneg | input | 2 | Guard invert flag per general write port |
| wb_dst | input | 2x6 | Destination register per general write port |
| wb_data | input | 2x64 | Write data per general write port |
| pw_vld | input | 1 | Predicate write valid |
| pw_pidx | input | 4 | Guard predicate index of the predicate write |
| pw_pneg | input | 1 | Guard invert flag of the predicate write |
| pw_dst | input | 4 | Destination predicate register |
| pw_val | input | 1 | Value written to the predicate register |

## Verification
The assertions assume that every input is driven to a known level at each rising edge after reset. They also assume that reset is held for at least one edge before the first request. With these assumptions the one-cycle relations between a committed write and the next read hold. The bench changes its inputs only on falling edges and drives all of them to defined values in every cycle, including the reset cycles. Write destinations are kept in a narrow range in the random phase, so that port collisions, writes to register 0 and same-cycle predicate updates occur often.

// File: rtl/rfp_pkg.sv
package rfp_pkg;
    parameter int NGPR  = 64;
    parameter int XLEN  = 64;
    parameter int NPR   = 16;
    parameter int NW    = 2;
    parameter int NRD   = 4;
    parameter int NPRD  = 2;
    localparam int AW   = $clog2(NGPR);
    localparam int PW   = $clog2(NPR);

    typedef logic [AW-1:0]   gaddr_t;
    typedef logic [PW-1:0]   paddr_t;
    typedef logic [XLEN-1:0] word_t;

    typedef struct packed {
        logic   vld;
        paddr_t pidx;
        logic   pneg;
        gaddr_t dst;
        word_t  data;
    } gwr_t;

    typedef struct packed {
        logic   vld;
        paddr_t pidx;
        logic   pneg;
        paddr_t dst;
        logic   val;
    } pwr_t;

    function automatic logic guard_pass(input logic [NPR-1:0] pv,
                                        input paddr_t idx, input logic neg);
        return pv[idx] ^ neg;
    endfunction
endpackage

// File: rtl/rfp_guard.sv
module rfp_guard
    import rfp_pkg::*;
(
    input  logic [NPR-1:0] pvec,
    input  logic           vld,
    input  paddr_t         pidx,
    input  logic           pneg,
    output logic           go
);
    always_comb go = vld & guard_pass(pvec, pidx, pneg);
endmodule

// File: rtl/rfp_pred_bank.sv
module rfp_pred_bank
    import rfp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_go,
    input  paddr_t               wr_dst,
    input  logic                 wr_val,
    input  paddr_t [NPRD-1:0]    rd_idx,
    output logic   [NPRD-1:0]    rd_val,
    output logic   [NPR-1:0]     pvec
);
    logic [NPR-1:1] pstore;

    always_ff @(posedge clk) begin
        if (rst) begin
            pstore <= '0;
        end else if (wr_go && wr_dst != '0) begin
            pstore[wr_dst] <= wr_val;
        end
    end

    assign pvec = {pstore, 1'b1};

    for (genvar r = 0; r < NPRD; r++) begin : g_prd
        assign rd_val[r] = pvec[rd_idx[r]];

        AST_PRED_ZERO_ONE: assert property (@(posedge clk) disable iff (rst)
            (rd_idx[r] == '0) |-> rd_val[r]) else $error("pred 0 not one"); // R3
    end
endmodule

// File: rtl/rfp_gpr_bank.sv
module rfp_gpr_bank
    import rfp_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  gwr_t   [NW-1:0]     wr,
    input  logic   [NW-1:0]     wr_go,
    input  gaddr_t [NRD-1:0]    rd_addr,
    output word_t  [NRD-1:0]    rd_data
);
    word_t mem [1:NGPR-1];

    // later ports overwrite earlier ones in the loop: highest port wins
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 1; i < NGPR; i++) mem[i] <= '0;
        end else begin
            for (int w = 0; w < NW; w++) begin
                if (wr_go[w] && wr[w].dst != '0) mem[wr[w].dst] <= wr[w].data;
            end
        end
    end

    for (genvar r = 0; r < NRD; r++) begin : g_rd
        always_comb begin
            if (rd_addr[r] == '0) rd_data[r] = '0;
            else                  rd_data[r] = mem[rd_addr[r]];
        end

        AST_GPR_ZERO_READ: assert property (@(posedge clk) disable iff (rst)
            (rd_addr[r] == '0) |-> (rd_data[r] == '0)) else $error("r0 nonzero"); // R1
    end
endmodule

// File: rtl/rfp_regfile.sv
module rfp_regfile
    import rfp_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NRD-1:0][AW-1:0]     rd_addr,
    output logic [NRD-1:0][XLEN-1:0]   rd_data,
    input  logic [NPRD-1:0][PW-1:0]    prd_idx,
    output logic [NPRD-1:0]            prd_val,
    input  logic [NW-1:0]              wb_vld,
    input  logic [NW-1:0][PW-1:0]      wb_pidx,
    input  logic [NW-1:0]              wb_pneg,
    input  logic [NW-1:0][AW-1:0]      wb_dst,
    input  logic [NW-1:0][XLEN-1:0]    wb_data,
    input  logic                       pw_vld,
    input  logic [PW-1:0]              pw_pidx,
    input  logic                       pw_pneg,
    input  logic [PW-1:0]              pw_dst,
    input  logic                       pw_val
);
    gwr_t [NW-1:0]  gwr;
    logic [NW-1:0]  ggo;
    pwr_t           pwr;
    logic           pgo;
    logic [NPR-1:0] pvec;

    for (genvar w = 0; w < NW; w++) begin : g_wp
        assign gwr[w] = '{vld: wb_vld[w], pidx: wb_pidx[w], pneg: wb_pneg[w],
                          dst: wb_dst[w], data: wb_data[w]};
        rfp_guard u_guard (
            .pvec (pvec),
            .vld  (gwr[w].vld),
            .pidx (gwr[w].pidx),
            .pneg (gwr[w].pneg),
            .go   (ggo[w])
        );
    end

    assign pwr = '{vld: pw_vld, pidx: pw_pidx, pneg: pw_pneg, dst: pw_dst, val: pw_val};

    rfp_guard u_pguard (
        .pvec (pvec),
        .vld  (pwr.vld),
        .pidx (pwr.pidx),
        .pneg (pwr.pneg),
        .go   (pgo)
    );

    rfp_gpr_bank u_gpr (
        .clk     (clk),
        .rst     (rst),
        .wr      (gwr),
        .wr_go   (ggo),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    rfp_pred_bank u_pred (
        .clk    (clk),
        .rst    (rst),
        .wr_go  (pgo),
        .wr_dst (pwr.dst),
        .wr_val (pwr.val),
        .rd_idx (prd_idx),
        .rd_val (prd_val),
        .pvec   (pvec)
    );

    // assertion support: previous cycle was out of reset
    logic arm;
    logic hit0;
    always_ff @(posedge clk) arm <= !rst;
    always_comb begin
        hit0 = 1'b0;
        for (int w = 0; w < NW; w++)
            if (ggo[w] && wb_dst[w] == rd_addr[0]) hit0 = 1'b1;
    end

    AST_HOLD_UNWRITTEN: assert property (@(posedge clk) disable iff (rst)
        (arm && !$past(hit0) && $stable(rd_addr[0])) |-> $stable(rd_data[0]))
        else $error("unwritten register changed"); // R4

    AST_TOP_PORT_WINS: assert property (@(posedge clk) disable iff (rst)
        (arm && $past(ggo[NW-1]) && $past(wb_dst[NW-1]) != '0
             && rd_addr[0] == $past(wb_dst[NW-1]))
        |-> (rd_data[0] == $past(wb_data[NW-1])))
        else $error("highest port data lost"); // R7

    AST_PRED_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        (arm && $past(pgo) && $past(pw_dst) != '0 && prd_idx[0] == $past(pw_dst))
        |-> (prd_val[0] == $past(pw_val)))
        else $error("predicate write lost"); // R5
endmodule

// File: tb/tb_rfp_regfile.sv
module tb_rfp_regfile;
    import rfp_pkg::*;
    localparam int CLK_PERIOD = 10;

    logic                       clk = 1'b0;
    logic                       rst;
    logic [NRD-1:0][AW-1:0]     rd_addr;
    logic [NRD-1:0][XLEN-1:0]   rd_data;
    logic [NPRD-1:0][PW-1:0]    prd_idx;
    logic [NPRD-1:0]            prd_val;
    logic [NW-1:0]              wb_vld;
    logic [NW-1:0][PW-1:0]      wb_pidx;
    logic [NW-1:0]              wb_pneg;
    logic [NW-1:0][AW-1:0]      wb_dst;
    logic [NW-1:0][XLEN-1:0]    wb_data;
    logic                       pw_vld;
    logic [PW-1:0]              pw_pidx;
    logic                       pw_pneg;
    logic [PW-1:0]              pw_dst;
    logic                       pw_val;

    always #(CLK_PERIOD/2) clk = ~clk;

    rfp_regfile dut (.*);

    // behavioural reference state
    logic [XLEN-1:0] ref_gpr [NGPR];
    logic            ref_pr  [NPR];
    int    checks = 0;
    int    errors = 0;
    string tag    = "R9";

    task automatic cmp(string t, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", t, act, exp);
        end
    endtask

    task automatic check_all();
        for (int r = 0; r < NRD; r++)
            cmp(tag, rd_data[r], ref_gpr[rd_addr[r]]);
        for (int r = 0; r < NPRD; r++)
            cmp(tag, {63'd0, prd_val[r]}, {63'd0, ref_pr[prd_idx[r]]});
    endtask

    task automatic model_edge();
        logic go [NW];
        logic pgo;
        if (rst) begin
            for (int i = 0; i < NGPR; i++) ref_gpr[i] = '0;
            for (int i = 0; i < NPR; i++)  ref_pr[i]  = (i == 0);
            return;
        end
        for (int w = 0; w < NW; w++)
            go[w] = wb_vld[w] && (ref_pr[wb_pidx[w]] != wb_pneg[w]);
        pgo = pw_vld && (ref_pr[pw_pidx] != pw_pneg);
        for (int w = 0; w < NW; w++)
            if (go[w] && wb_dst[w] != 0) ref_gpr[wb_dst[w]] = wb_data[w];
        if (pgo && pw_dst != 0) ref_pr[pw_dst] = pw_val;
    endtask

    // inputs are held from a falling edge; check, take the rising edge, return at falling edge
    task automatic tick();
        #1;
        check_all();
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic idle();
        wb_vld = '0; wb_pidx = '0; wb_pneg = '0; wb_dst = '0; wb_data = '0;
        pw_vld = 0; pw_pidx = '0; pw_pneg = 0; pw_dst = '0; pw_val = 0;
    endtask

    task automatic gw(int p, int dst, logic [XLEN-1:0] d, int pi, logic pn);
        wb_vld[p] = 1; wb_dst[p] = AW'(dst); wb_data[p] = d;
        wb_pidx[p] = PW'(pi); wb_pneg[p] = pn;
    endtask

    task automatic pwrite(int dst, logic v, int pi, logic pn);
        pw_vld = 1; pw_dst = PW'(dst); pw_val = v; pw_pidx = PW'(pi); pw_pneg = pn;
    endtask

    task automatic sweep();
        for (int b = 0; b < NGPR; b += NRD) begin
            for (int r = 0; r < NRD; r++) rd_addr[r] = AW'(b + r);
            prd_idx[0] = PW'((b / NRD) % NPR);
            prd_idx[1] = PW'(((b / NRD) + 1) % NPR);
            tick();
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog act=running exp=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < NGPR; i++) ref_gpr[i] = 'x;
        for (int i = 0; i < NPR; i++)  ref_pr[i]  = 1'bx;
        idle();
        rd_addr = '0; prd_idx = '0;
        rst = 1;
        @(negedge clk);
        @(posedge clk); model_edge();
        @(negedge clk); @(posedge clk); model_edge();
        @(negedge clk);
        rst = 0;

        tag = "R9"; sweep();

        // R1: unconditional writes to register 0 on both ports
        tag = "R1";
        rd_addr = '0; gw(0, 0, 64'hDEAD, 0, 0); gw(1, 0, 64'hBEEF, 0, 0); tick();
        idle(); tick();

        // R2: write reg 5, read it in the same cycle and the next
        tag = "R2";
        rd_addr[0] = 6'd5; rd_addr[1] = 6'd5; gw(0, 5, 64'h1234_5678_9ABC_DEF0, 0, 0); tick();
        idle(); tick();

        // R3: attempt to clear predicate 0
        tag = "R3";
        prd_idx[0] = 4'd0; pwrite(0, 0, 0, 0); tick();
        idle(); tick();

        // R5: set predicate 3 unconditionally
        tag = "R5";
        prd_idx[0] = 4'd3; prd_idx[1] = 4'd4; pwrite(3, 1, 0, 0); tick();
        idle(); tick();

        // R4: guard on false pr4 suppresses, guard on true pr3 commits
        tag = "R4";
        rd_addr[0] = 6'd7; gw(0, 7, 64'hAAAA, 4, 0); tick();
        idle(); tick();
        gw(0, 7, 64'hBBBB, 3, 0); tick();
        idle(); tick();

        // R6: inverted false pr4 commits; inverted pr0 never commits
        tag = "R6";
        gw(0, 7, 64'hCCCC, 4, 1); tick();
        idle(); tick();
        gw(1, 7, 64'hDDDD, 0, 1); tick();
        idle(); tick();

        // R7: both ports to reg 9; then port 1 suppressed
        tag = "R7";
        rd_addr[0] = 6'd9; gw(0, 9, 64'h1111, 0, 0); gw(1, 9, 64'h2222, 0, 0); tick();
        idle(); tick();
        gw(0, 9, 64'h3333, 0, 0); gw(1, 9, 64'h4444, 4, 0); tick();
        idle(); tick();

        // R8: same-cycle predicate set does not enable a write guarded on it
        tag = "R8";
        rd_addr[0] = 6'd11; prd_idx[0] = 4'd4;
        pwrite(4, 1, 0, 0); gw(0, 11, 64'h5555, 4, 0); tick();
        idle(); tick();
        pwrite(5, 1, 4, 1); tick();
        idle(); prd_idx[0] = 4'd5; tick();

        // random traffic with narrow destinations
        tag = "R2";
        for (int n = 0; n < 3000; n++) begin
            for (int r = 0; r < NRD; r++) rd_addr[r] = AW'($urandom_range(0, 9));
            for (int r = 0; r < NPRD; r++) prd_idx[r] = PW'($urandom_range(0, 5));
            for (int w = 0; w < NW; w++) begin
                wb_vld[w] = 1'($urandom_range(0, 1));
                wb_pidx[w] = PW'($urandom_range(0, 5));
                wb_pneg[w] = 1'($urandom_range(0, 1));
                wb_dst[w] = AW'($urandom_range(0, 9));
                wb_data[w] = {$urandom, $urandom};
            end
            pw_vld = 1'($urandom_range(0, 1));
            pw_pidx = PW'($urandom_range(0, 5));
            pw_pneg = 1'($urandom_range(0, 1));
            pw_dst = PW'($urandom_range(0, 5));
            pw_val = 1'($urandom_range(0, 1));
            tick();
        end

        // R9: reset after traffic clears everything
        idle();
        tag = "R9";
        rst = 1; tick(); tick();
        rst = 0;
        sweep();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule